// File: doc/BRIEF.md
# Execute Unit with Flag Register and Condition Check

This block is the arithmetic step of a single-cycle processor datapath. It takes two 64-bit operands that earlier logic has already selected, together with the instruction class code and the function code. It returns the arithmetic result, a condition-met bit and the final register destination for the result.

The unit holds two status flags, zero and sign. Only arithmetic/logic instructions write them, and the write takes place at the clock edge that ends the instruction. Conditional jumps and conditional moves test the flags that were stored at an earlier edge. Later logic uses the condition-met bit to choose between a jump target and the fall-through address. A conditional move whose condition fails is cancelled by rewriting its destination to the all-ones null register code, so no register is written. The unit produces no separate write-enable signal.

Instruction class codes (4 bits): 2 = conditional move, 6 = arithmetic/logic, 7 = conditional jump. Every other code is a non-arithmetic instruction that uses the adder.

Top module: `aluc_exec`

## Requirements
- R1: For every class code other than 6, val_e equals alu_a + alu_b, taken modulo 2^64.
- R2: For class 6, the function code picks the operation: 0 gives alu_b + alu_a, 1 gives alu_b - alu_a, 2 gives alu_b AND alu_a, and 3 gives alu_b XOR alu_a.
- R3: Only a class-6 cycle writes the flags, at its closing rising edge. ZF is set when the 64-bit result is zero, and SF takes bit 63 of the result. A cycle with any other class code leaves both flags unchanged.
- R4: A condition is evaluated from the flags held since the last edge. The result of an arithmetic instruction affects conditions only from the following cycle onward.
- R5: The condition codes carried in the function code are: 0 always gives 1; 1 gives SF OR ZF; 2 gives SF; 3 gives ZF; 4 gives NOT ZF; 5 gives NOT SF; 6 gives NOT SF AND NOT ZF.
- R6: For class 2, a failed condition drives dst_out to 4'hF. A met condition passes dst_in through. val_e is the sum in both cases.
- R7: For every class code other than 2, dst_out equals dst_in. This includes a conditional jump whose condition fails.
- R8: cnd is 0 for every class code other than 2 and 7. It is also 0 for condition codes 7 to 15.
- R9: Reset is active-low and asynchronous. It sets ZF to 1 and SF to 0, and it does so while the reset is still held.
- R10: For class 6, function codes 4 to 15 select addition. The flags are still written from the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| alu_a | input | 64 | First operand, subtracted when subtracting |
| alu_b | input | 64 | Second operand |
| icode | input | 4 | Instruction class code |
| ifun | input | 4 | Function code: operation or condition |
| dst_in | input | 4 | Proposed destination register |
| val_e | output | 64 | Arithmetic result |
| cnd | output | 1 | Condition met, valid for classes 2 and 7 |
| dst_out | output | 4 | Final destination, 4'hF when cancelled |

## Verification
Two things can fall in one cycle when a conditional move comes straight after an arithmetic instruction. In that cycle the unit passes the move's operand sum through as val_e, and it decides whether to cancel the destination using flags written only at the edge just passed. The bench provokes this with back-to-back arithmetic then move pairs whose results flip ZF or SF. For each pair it judges val_e, cnd and dst_out against the flags the earlier instruction must have left. A separate case checks that a non-arithmetic cycle placed between the two leaves the outcome unchanged.

// File: rtl/aluc_pkg.sv
package aluc_pkg;
  localparam int DATA_W = 64;
  localparam int REG_W  = 4;
  localparam int CODE_W = 4;

  localparam logic [CODE_W-1:0] IC_CMOV = 4'h2;
  localparam logic [CODE_W-1:0] IC_OP   = 4'h6;
  localparam logic [CODE_W-1:0] IC_JXX  = 4'h7;

  typedef enum logic [1:0] {
    OP_ADD = 2'd0,
    OP_SUB = 2'd1,
    OP_AND = 2'd2,
    OP_XOR = 2'd3
  } alu_op_e;

  typedef enum logic [CODE_W-1:0] {
    CC_ALWAYS = 4'd0,
    CC_LE     = 4'd1,
    CC_LT     = 4'd2,
    CC_EQ     = 4'd3,
    CC_NE     = 4'd4,
    CC_GE     = 4'd5,
    CC_GT     = 4'd6
  } cond_e;
endpackage

// File: rtl/aluc_alu.sv
module aluc_alu
  import aluc_pkg::*;
#(
  parameter int W = DATA_W
) (
  input  alu_op_e      op,
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  output logic [W-1:0] res,
  output logic         res_zero,
  output logic         res_neg
);
  always_comb begin
    unique case (op)
      OP_ADD:  res = opb + opa;
      OP_SUB:  res = opb - opa;
      OP_AND:  res = opb & opa;
      default: res = opb ^ opa;
    endcase
  end

  assign res_zero = (res == '0);
  assign res_neg  = res[W-1];
endmodule

// File: rtl/aluc_flags.sv
module aluc_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic zf_in,
  input  logic sf_in,
  output logic zf_q,
  output logic sf_q
);
  logic zf_d, sf_d;

  always_comb begin
    zf_d = zf_q;
    sf_d = sf_q;
    if (wr_en) begin
      zf_d = zf_in;
      sf_d = sf_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      zf_q <= 1'b1;
      sf_q <= 1'b0;
    end else begin
      zf_q <= zf_d;
      sf_q <= sf_d;
    end
  end
endmodule

// File: rtl/aluc_cond.sv
module aluc_cond
  import aluc_pkg::*;
(
  input  logic [CODE_W-1:0] code,
  input  logic              zf,
  input  logic              sf,
  output logic              met
);
  always_comb begin
    unique case (code)
      CC_ALWAYS: met = 1'b1;
      CC_LE:     met = sf | zf;
      CC_LT:     met = sf;
      CC_EQ:     met = zf;
      CC_NE:     met = ~zf;
      CC_GE:     met = ~sf;
      CC_GT:     met = ~sf & ~zf;
      default:   met = 1'b0;
    endcase
  end
endmodule

// File: rtl/aluc_exec.sv
module aluc_exec
  import aluc_pkg::*;
#(
  parameter int W  = DATA_W,
  parameter int RW = REG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [W-1:0]      alu_a,
  input  logic [W-1:0]      alu_b,
  input  logic [CODE_W-1:0] icode,
  input  logic [CODE_W-1:0] ifun,
  input  logic [RW-1:0]     dst_in,
  output logic [W-1:0]      val_e,
  output logic              cnd,
  output logic [RW-1:0]     dst_out
);
  localparam logic [RW-1:0] NULL_REG = {RW{1'b1}};

  logic    is_op, is_cmov, is_cond;
  alu_op_e op_sel;
  logic    res_zero, res_neg;
  logic    flag_zf, flag_sf;
  logic    cond_met;

  assign is_op   = (icode == IC_OP);
  assign is_cmov = (icode == IC_CMOV);
  assign is_cond = is_cmov | (icode == IC_JXX);

  always_comb begin
    op_sel = OP_ADD;
    if (is_op && (ifun < 4'd4)) op_sel = alu_op_e'(ifun[1:0]);
  end

  aluc_alu #(.W(W)) alu_i (
    .op       (op_sel),
    .opa      (alu_a),
    .opb      (alu_b),
    .res      (val_e),
    .res_zero (res_zero),
    .res_neg  (res_neg)
  );

  aluc_flags flags_i (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (is_op),
    .zf_in (res_zero),
    .sf_in (res_neg),
    .zf_q  (flag_zf),
    .sf_q  (flag_sf)
  );

  aluc_cond cond_i (
    .code (ifun),
    .zf   (flag_zf),
    .sf   (flag_sf),
    .met  (cond_met)
  );

  assign cnd     = is_cond & cond_met;
  assign dst_out = (is_cmov && !cond_met) ? NULL_REG : dst_in;
endmodule

// File: rtl/aluc_exec_chk.sv
module aluc_exec_chk
  import aluc_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [63:0]       alu_a,
  input logic [63:0]       alu_b,
  input logic [CODE_W-1:0] icode,
  input logic [3:0]        dst_in,
  input logic [63:0]       val_e,
  input logic              cnd,
  input logic [3:0]        dst_out,
  input logic              flag_zf,
  input logic              flag_sf
);
  AST_ADD_DEFAULT: assert property (@(posedge clk) disable iff (!rst_n)
    (icode != IC_OP) |-> (val_e == alu_a + alu_b)); // R1

  AST_FLAGS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (icode != IC_OP) |=> $stable({flag_zf, flag_sf})); // R3

  AST_FLAGS_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (icode == IC_OP) |=> (flag_zf == ($past(val_e) == 64'd0)) && (flag_sf == $past(val_e[63]))); // R3

  AST_CMOV_CANCEL: assert property (@(posedge clk) disable iff (!rst_n)
    (icode == IC_CMOV && !cnd) |-> (dst_out == 4'hF)); // R6

  AST_DST_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (icode != IC_CMOV) |-> (dst_out == dst_in)); // R7

  AST_CND_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (icode != IC_CMOV && icode != IC_JXX) |-> !cnd); // R8
endmodule

bind aluc_exec aluc_exec_chk chk_i (
  .clk     (clk),
  .rst_n   (rst_n),
  .alu_a   (alu_a),
  .alu_b   (alu_b),
  .icode   (icode),
  .dst_in  (dst_in),
  .val_e   (val_e),
  .cnd     (cnd),
  .dst_out (dst_out),
  .flag_zf (flag_zf),
  .flag_sf (flag_sf)
);

// File: tb/aluc_exec_tb.sv
module aluc_exec_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 24;

  typedef struct packed {
    logic [3:0]  ic;
    logic [3:0]  fn;
    logic [63:0] a;
    logic [63:0] b;
    logic [3:0]  d;
    logic [63:0] ev;
    logic        ec;
    logic [3:0]  ed;
    logic [3:0]  rq;
  } vec_t;

  // Flags after reset: ZF=1 SF=0; each row's flags follow from earlier class-6 rows.
  localparam vec_t VECS [NVEC] = '{
    '{4'h7, 4'h3, 64'h0,  64'h0,  4'h4, 64'h0,  1'b1, 4'h4, 4'd9},  // R9 eq after reset
    '{4'h7, 4'h2, 64'h0,  64'h0,  4'h4, 64'h0,  1'b0, 4'h4, 4'd9},  // R9 lt after reset
    '{4'h6, 4'h0, 64'h5,  64'h7,  4'h3, 64'd12, 1'b0, 4'h3, 4'd2},  // R2 add -> Z0 S0
    '{4'h2, 4'h3, 64'h11, 64'h0,  4'h2, 64'h11, 1'b0, 4'hF, 4'd6},  // R6 cancel, R4
    '{4'h2, 4'h4, 64'h22, 64'h0,  4'h2, 64'h22, 1'b1, 4'h2, 4'd6},  // R6 pass
    '{4'h6, 4'h1, 64'h9,  64'h4,  4'h1, 64'hFFFF_FFFF_FFFF_FFFB, 1'b0, 4'h1, 4'd2}, // R2 sub -> Z0 S1
    '{4'h7, 4'h2, 64'h0,  64'h0,  4'hF, 64'h0,  1'b1, 4'hF, 4'd5},  // R5 lt
    '{4'h7, 4'h5, 64'h0,  64'h0,  4'h8, 64'h0,  1'b0, 4'h8, 4'd7},  // R5 ge, R7 jump fail
    '{4'h7, 4'h1, 64'h0,  64'h0,  4'h8, 64'h0,  1'b1, 4'h8, 4'd5},  // R5 le
    '{4'h7, 4'h6, 64'h0,  64'h0,  4'h8, 64'h0,  1'b0, 4'h8, 4'd5},  // R5 gt
    '{4'h6, 4'h2, 64'hF0, 64'h0F, 4'h1, 64'h0,  1'b0, 4'h1, 4'd2},  // R2 and -> Z1 S0
    '{4'h7, 4'h3, 64'h0,  64'h0,  4'h8, 64'h0,  1'b1, 4'h8, 4'd4},  // R4 eq next cycle
    '{4'h3, 4'h0, 64'h100,64'h0,  4'h7, 64'h100,1'b0, 4'h7, 4'd3},  // R3 no flag write
    '{4'h2, 4'h1, 64'h33, 64'h0,  4'h5, 64'h33, 1'b1, 4'h5, 4'd3},  // R3 le still true
    '{4'h6, 4'h3, 64'hFF, 64'h0F, 4'h1, 64'hF0, 1'b0, 4'h1, 4'd2},  // R2 xor -> Z0 S0
    '{4'h2, 4'h6, 64'h44, 64'h0,  4'h6, 64'h44, 1'b1, 4'h6, 4'd5},  // R5 gt true
    '{4'h2, 4'h7, 64'h45, 64'h0,  4'h6, 64'h45, 1'b0, 4'hF, 4'd8},  // R8 unknown cond
    '{4'h6, 4'h5, 64'h1,  64'h2,  4'h1, 64'h3,  1'b0, 4'h1, 4'd10}, // R10 -> Z0 S0
    '{4'hA, 4'h0, 64'hFFFF_FFFF_FFFF_FFF8, 64'h1000, 4'h4, 64'hFF8, 1'b0, 4'h4, 4'd1}, // R1
    '{4'h6, 4'h0, 64'h1,  64'hFFFF_FFFF_FFFF_FFFF, 4'h1, 64'h0, 1'b0, 4'h1, 4'd3}, // R3 wrap -> Z1 S0
    '{4'h2, 4'h0, 64'h55, 64'h0,  4'h3, 64'h55, 1'b1, 4'h3, 4'd5},  // R5 always
    '{4'h7, 4'h3, 64'h0,  64'h0,  4'h8, 64'h0,  1'b1, 4'h8, 4'd3},  // R3 eq
    '{4'h6, 4'h0, 64'h8000_0000_0000_0000, 64'h0, 4'h1, 64'h8000_0000_0000_0000, 1'b0, 4'h1, 4'd3}, // R3 -> Z0 S1
    '{4'h2, 4'h5, 64'h66, 64'h0,  4'h9, 64'h66, 1'b0, 4'hF, 4'd6}   // R6 ge false
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic [63:0] alu_a, alu_b;
  logic [3:0]  icode, ifun, dst_in;
  logic [63:0] val_e;
  logic        cnd;
  logic [3:0]  dst_out;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  aluc_exec dut_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .alu_a   (alu_a),
    .alu_b   (alu_b),
    .icode   (icode),
    .ifun    (ifun),
    .dst_in  (dst_in),
    .val_e   (val_e),
    .cnd     (cnd),
    .dst_out (dst_out)
  );

  task automatic drive(input logic [3:0] ic, input logic [3:0] fn,
                       input logic [63:0] a, input logic [63:0] b, input logic [3:0] d);
    icode = ic; ifun = fn; alu_a = a; alu_b = b; dst_in = d;
  endtask

  task automatic check(input string tag, input logic [63:0] ev, input logic ec, input logic [3:0] ed);
    n_tests++;
    if (val_e !== ev || cnd !== ec || dst_out !== ed) begin
      n_fail++;
      $display("FAIL %s: val_e=%h cnd=%b dst=%h expected val_e=%h cnd=%b dst=%h",
               tag, val_e, cnd, dst_out, ev, ec, ed);
    end
  endtask

  initial begin
    rst_n = 1'b0;
    drive(4'h7, 4'h3, 64'h0, 64'h0, 4'h4);
    repeat (2) @(negedge clk);
    #1 check("R9 eq during reset", 64'h0, 1'b1, 4'h4);
    drive(4'h7, 4'h2, 64'h0, 64'h0, 4'h4);
    #1 check("R9 lt during reset", 64'h0, 1'b0, 4'h4);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      drive(VECS[i].ic, VECS[i].fn, VECS[i].a, VECS[i].b, VECS[i].d);
      #1 check($sformatf("R%0d row %0d", VECS[i].rq, i), VECS[i].ev, VECS[i].ec, VECS[i].ed);
    end
    // Flags now Z0 S1.

    // R4: arithmetic result is not seen in its own cycle; jump after sees it
    @(negedge clk);
    drive(4'h6, 4'h1, 64'h7, 64'h7, 4'h2);
    #1 check("R4 op cycle", 64'h0, 1'b0, 4'h2);
    @(negedge clk);
    drive(4'h7, 4'h3, 64'h0, 64'h0, 4'h2);
    #1 check("R4 eq after zero result", 64'h0, 1'b1, 4'h2);

    // R2 sub order: alu_b - alu_a
    @(negedge clk);
    drive(4'h6, 4'h1, 64'h3, 64'h10, 4'h2);
    #1 check("R2 sub order", 64'hD, 1'b0, 4'h2);
    // flags now Z0 S0

    // R9: asynchronous reset mid-run restores ZF=1 SF=0 immediately
    @(negedge clk);
    drive(4'h7, 4'h4, 64'h0, 64'h0, 4'h2);
    #1 check("R9 ne before reset", 64'h0, 1'b1, 4'h2);
    #1 rst_n = 1'b0;
    #1 check("R9 ne in async reset", 64'h0, 1'b0, 4'h2);
    @(negedge clk);
    rst_n = 1'b1;
    drive(4'h2, 4'h2, 64'h9, 64'h1, 4'hB);
    #1 check("R9 lt after reset", 64'hA, 1'b0, 4'hF);

    // R8: condition class code ignored on non-conditional class
    @(negedge clk);
    drive(4'h5, 4'h0, 64'h2, 64'h2, 4'hC);
    #1 check("R8 non-cond class", 64'h4, 1'b0, 4'hC);

    done = 1'b1;
  end

  initial begin
    fork
      begin
        wait (done);
      end
      begin
        repeat (2000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: bench did not finish");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule